// File: doc/BRIEF.md
# Transmit Channel Interrupt Status Unit

This unit turns the status flags of one audio transmit channel into a raw interrupt status word, gates that word with a software-loaded enable mask, and drives one level-sensitive interrupt line. Three interrupt sources are produced. The first is a transmit request that follows the FIFO half-empty flag. The second is a transmit-done condition that holds while the FIFO is empty and the transmitter is idle. The third is an underrun flag that stays set until software clears it through a write-one-to-clear word.

The FIFO and drain logic next to the unit raise `undr_set` whenever a drain leaves the FIFO empty. The unit does not latch the level flags. Their new value appears in the raw word in the cycle it arrives, so the status follows every register write and every drain event. A narrower read-back port returns the low part of the raw word, which lets software read every interrupt source with a single access.

Top module: `ir_chan_irq`

## Requirements
- R1: Out of reset the enable mask is zero, the sticky underrun flag is zero, `masked_status` is zero and `irq` is low.
- R2: A cycle with `undr_set` high sets raw bit 2 (underrun) from the next clock edge on. The bit stays set over later cycles until it is cleared.
- R3: A cycle with `clr_wr` high and bit 0 of `clr_wdata` high clears raw bit 2 at the next edge. A clear write with bit 0 low has no effect on it.
- R4: When `undr_set` and a valid clear arrive in the same cycle, raw bit 2 is set after the edge, because the new underrun wins.
- R5: Raw bit 1 (transmit request) equals `half_empty` in the same cycle.
- R6: Raw bit 0 (transmit done) is high only when `fifo_empty` is high and `tx_busy` is low.
- R7: A cycle with `en_wr` high loads `en_wdata` into the enable mask at the next edge. `masked_status` always equals the raw word ANDed with that mask.
- R8: `irq` is registered. After each edge it is high exactly when `masked_status` was nonzero just before that edge.
- R9: `all_ints` returns the low 7 bits of the raw word.
- R10: Raw bits other than 0, 1 and 2 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| undr_set | input | 1 | Pulse from the drain logic: FIFO ran empty |
| half_empty | input | 1 | FIFO level at or below half |
| fifo_empty | input | 1 | FIFO holds no samples |
| tx_busy | input | 1 | Transmitter still shifting a frame |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | STAT_W (8) | New enable mask |
| clr_wr | input | 1 | Clear word write strobe |
| clr_wdata | input | STAT_W (8) | Clear word, bit 0 clears underrun |
| raw_status | output | STAT_W (8) | Raw interrupt status |
| masked_status | output | STAT_W (8) | Raw status ANDed with enable mask |
| irq | output | 1 | Registered interrupt line |
| all_ints | output | READ_W (7) | Low part of raw status for combined read |

## Verification
The bench builds the unit with its default widths: an 8-bit status word and a 7-bit read-back. With these widths the raw word has one bit above the read-back. This makes it possible to observe both the truncation of `all_ints` and the zero value of the unused upper raw bits. Every value of the flag triple, the set-versus-clear collision and the one-cycle `irq` latency can all be reached at these widths.

// File: rtl/ir_pkg.sv
// Shared bit positions and source bundle for the channel interrupt unit.
package ir_pkg;
    localparam int DONE_POS     = 0;
    localparam int REQ_POS      = 1;
    localparam int UNDR_POS     = 2;
    localparam int CLR_UNDR_POS = 0;

    typedef struct packed {
        logic undr;
        logic req;
        logic done;
    } irq_src_t;
endpackage

// File: rtl/ir_undr_latch.sv
// Sticky underrun flag.
// Assumes set_i is a one-cycle pulse; a set in the same cycle as a clear wins.
module ir_undr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag until an explicit clear, giving priority to a new set.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/ir_src_map.sv
// Places the interrupt sources at their bit positions in the raw word.
// Assumes every source position is below STAT_W; other bits read zero.
module ir_src_map #(
    parameter int STAT_W = 8
) (
    input  ir_pkg::irq_src_t src_i,
    output logic [STAT_W-1:0] raw_o
);
    import ir_pkg::*;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == DONE_POS) begin : g_done
            assign raw_o[i] = src_i.done;
        end else if (i == REQ_POS) begin : g_req
            assign raw_o[i] = src_i.req;
        end else if (i == UNDR_POS) begin : g_undr
            assign raw_o[i] = src_i.undr;
        end else begin : g_zero
            assign raw_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ir_gate.sv
// Enable mask register, masked status and registered interrupt line.
// Assumes the mask is written whole; the irq line lags its inputs by one edge.
module ir_gate #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr_i,
    input  logic [STAT_W-1:0] en_wdata_i,
    input  logic [STAT_W-1:0] raw_i,
    output logic [STAT_W-1:0] masked_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] mask_q;

    // Load the enable mask on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (en_wr_i) mask_q <= en_wdata_i;
    end

    // Gate the raw word with the current mask.
    always_comb masked_o = raw_i & mask_q;

    // Register the OR of the masked word as the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |masked_o;
    end
endmodule

// File: rtl/ir_chan_irq.sv
// Top of the transmit channel interrupt unit.
// Assumes level flags come straight from the FIFO and undr_set is a pulse.
module ir_chan_irq #(
    parameter int STAT_W = 8,
    parameter int READ_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              undr_set,
    input  logic              half_empty,
    input  logic              fifo_empty,
    input  logic              tx_busy,
    input  logic              en_wr,
    input  logic [STAT_W-1:0] en_wdata,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_wdata,
    output logic [STAT_W-1:0] raw_status,
    output logic [STAT_W-1:0] masked_status,
    output logic              irq,
    output logic [READ_W-1:0] all_ints
);
    import ir_pkg::*;

    localparam logic [STAT_W-1:0] CLR_MASK = STAT_W'(1) << CLR_UNDR_POS;

    logic     clr_hit;
    logic     undr_q;
    irq_src_t src;

    // Decode a clear write that targets the underrun bit.
    always_comb clr_hit = clr_wr && ((clr_wdata & CLR_MASK) != '0);

    ir_undr_latch u_undr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (undr_set),
        .clr_i  (clr_hit),
        .flag_o (undr_q)
    );

    // Collect the three interrupt sources.
    always_comb begin
        src.undr = undr_q;
        src.req  = half_empty;
        src.done = fifo_empty && !tx_busy;
    end

    ir_src_map #(.STAT_W(STAT_W)) u_map (
        .src_i (src),
        .raw_o (raw_status)
    );

    ir_gate #(.STAT_W(STAT_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr_i    (en_wr),
        .en_wdata_i (en_wdata),
        .raw_i      (raw_status),
        .masked_o   (masked_status),
        .irq_o      (irq)
    );

    // Expose the low part of the raw word for the combined read.
    always_comb all_ints = raw_status[READ_W-1:0];
endmodule

// File: rtl/ir_chan_irq_chk.sv
// Temporal checks on the interrupt unit, bound to its top.
module ir_chan_irq_chk #(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              undr_set,
    input logic              clr_wr,
    input logic [STAT_W-1:0] clr_wdata,
    input logic [STAT_W-1:0] raw_status,
    input logic [STAT_W-1:0] masked_status,
    input logic              irq
);
    import ir_pkg::*;

    // R2
    undr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undr_set |=> raw_status[UNDR_POS]);

    // R3
    undr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_status[UNDR_POS]) |-> $past(clr_wr && clr_wdata[CLR_UNDR_POS]));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (undr_set && clr_wr && clr_wdata[CLR_UNDR_POS]) |=> raw_status[UNDR_POS]);

    // R8
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(masked_status != '0)));
endmodule

bind ir_chan_irq ir_chan_irq_chk #(.STAT_W(STAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .undr_set      (undr_set),
    .clr_wr        (clr_wr),
    .clr_wdata     (clr_wdata),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq)
);

// File: tb/ir_chan_irq_test.sv
module ir_chan_irq_test;
    localparam int SW = 8;
    localparam int RW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          undr_set = 1'b0, half_empty = 1'b0, fifo_empty = 1'b0, tx_busy = 1'b0;
    logic          en_wr = 1'b0, clr_wr = 1'b0;
    logic [SW-1:0] en_wdata = '0, clr_wdata = '0;
    logic [SW-1:0] raw_status, masked_status;
    logic          irq;
    logic [RW-1:0] all_ints;

    int total = 0;
    int bad = 0;
    logic exp_ur = 1'b0;
    logic [SW-1:0] exp_mask = '0;

    ir_chan_irq uut (.*);

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] model_raw();
        logic [SW-1:0] r = '0;
        r[0] = fifo_empty && !tx_busy;
        r[1] = half_empty;
        r[2] = exp_ur;
        return r;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; half_empty = 1'b1; fifo_empty = 1'b1; tx_busy = 1'b0;
        tick(); tick();
        rst_n = 1'b1; #1;
        check("R1 masked", 32'(masked_status), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 raw", 32'(raw_status), 32'h03);
    endtask

    task automatic t_flags();
        for (int k = 0; k < 8; k++) begin
            {half_empty, fifo_empty, tx_busy} = 3'(k);
            #1;
            check("R5", 32'(raw_status[1]), 32'(half_empty));
            check("R6", 32'(raw_status[0]), 32'(fifo_empty && !tx_busy));
            check("R9", 32'(all_ints), 32'(model_raw()));
            check("R10", 32'(raw_status[SW-1:3]), 32'h0);
        end
    endtask

    task automatic t_underrun();
        undr_set = 1'b1; tick(); undr_set = 1'b0; exp_ur = 1'b1;
        check("R2 set", 32'(raw_status[2]), 32'h1);
        tick(); tick();
        check("R2 hold", 32'(raw_status[2]), 32'h1);
        clr_wr = 1'b1; clr_wdata = 8'hFE; tick(); clr_wr = 1'b0;
        check("R3 wrong bit ignored", 32'(raw_status[2]), 32'h1);
        clr_wr = 1'b1; clr_wdata = 8'h01; tick(); clr_wr = 1'b0; exp_ur = 1'b0;
        check("R3 cleared", 32'(raw_status[2]), 32'h0);
    endtask

    task automatic t_race();
        undr_set = 1'b1; clr_wr = 1'b1; clr_wdata = 8'h01; tick();
        undr_set = 1'b0; clr_wr = 1'b0; exp_ur = 1'b1;
        check("R4 set wins", 32'(raw_status[2]), 32'h1);
        clr_wr = 1'b1; tick(); clr_wr = 1'b0; exp_ur = 1'b0;
        check("R4 cleanup", 32'(raw_status[2]), 32'h0);
    endtask

    task automatic t_mask_irq();
        {half_empty, fifo_empty, tx_busy} = 3'b000;
        en_wr = 1'b1; en_wdata = 8'h04; tick(); en_wr = 1'b0; exp_mask = 8'h04;
        check("R7 masked none", 32'(masked_status), 32'h0);
        tick();
        check("R8 irq low", 32'(irq), 32'h0);
        undr_set = 1'b1; tick(); undr_set = 1'b0; exp_ur = 1'b1;
        check("R7 masked ur", 32'(masked_status), 32'(model_raw() & exp_mask));
        check("R8 lag", 32'(irq), 32'h0);
        tick();
        check("R8 irq high", 32'(irq), 32'h1);
        en_wr = 1'b1; en_wdata = 8'h03; tick(); en_wr = 1'b0; exp_mask = 8'h03;
        check("R7 remask", 32'(masked_status), 32'h0);
        tick();
        check("R8 irq drop", 32'(irq), 32'h0);
        half_empty = 1'b1; #1;
        check("R7 req", 32'(masked_status), 32'(model_raw() & exp_mask));
        tick();
        check("R8 irq req", 32'(irq), 32'h1);
        half_empty = 1'b0; fifo_empty = 1'b1; tx_busy = 1'b1; tick();
        check("R8 busy blocks done", 32'(irq), 32'h0);
        tx_busy = 1'b0; tick();
        check("R6 done irq", 32'(irq), 32'h1);
    endtask

    initial begin
        t_reset();
        t_flags();
        t_underrun();
        t_race();
        t_mask_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule